// File: doc/BRIEF.md
# Peripheral DMA Pointer-Counter Engine

This block is a two-direction byte DMA channel that sits beside one peripheral. It has a receive direction and a transmit direction. In the receive direction it takes bytes from the peripheral and writes them to memory. In the transmit direction it reads bytes from memory and hands them to the peripheral.

Each direction keeps two address/length pairs. The active pair is the one the engine works on. The queued pair is loaded by software ahead of time. When the active length runs out, the queued pair moves into the active slot on its own, so a second buffer follows the first with no software action in between. Software starts and stops each direction with one-shot command bits. It watches two level flags per direction: one for the end of the active buffer, and one for the moment both buffers are used up.

The memory side is a single-beat port. A write completes in the cycle it is issued. Read data returns one cycle after the request.

Top module: `pdc_chan`

## Requirements
- R1: Registers sit on 32-bit words. The word index is `reg_addr[5:2]`: 0 rx active address, 1 rx active length, 2 tx active address, 3 tx active length, 4 rx queued address, 5 rx queued length, 6 tx queued address, 7 tx queued length, 8 command, 9 status. Reads are combinational and zero-extended. Writes keep only the low AW (address) or CW (length) bits.
- R2: After reset, every address and length register reads 0, both directions are disabled, and all four flags are 1.
- R3: A command write changes the enables as follows: bit 0 enables rx, bit 1 disables rx, bit 8 enables tx, bit 9 disables tx. A direction whose bits are both 0 keeps its state. In status, bit 0 is the rx enable, bit 8 is the tx enable, and all other bits read 0.
- R4: A command write that sets both the enable bit and the disable bit of a direction leaves that direction disabled.
- R5: An rx transfer happens in a cycle where rx is enabled, the rx active length is nonzero, `per_rx_ready` is high and no tx read is outstanding. In that cycle `per_rx_take` pulses, and a memory write of `per_rx_data` goes to the rx active address. At the next edge the address goes up by 1 and the length goes down by 1.
- R6: A tx transfer needs tx enabled, a nonzero tx active length, `per_tx_ready` high and no rx transfer starting. It issues a memory read at the tx active address. One cycle later `per_tx_load` pulses with `per_tx_data` equal to the returned byte, and the address goes up by 1 and the length goes down by 1.
- R7: No transfer starts in a direction that is disabled or whose active length is 0.
- R8: When a direction's active length is 0 and its queued length is nonzero, the next edge copies the queued address and length into the active pair and clears the queued length. This happens whether or not the direction is enabled.
- R9: `end_rx` and `end_tx` are 1 exactly when the active length of that direction is 0.
- R10: `rx_full` and `tx_empty` are 1 exactly when both the active and the queued length of that direction are 0.
- R11: When rx and tx could both start in the same cycle, rx takes the memory port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Read data, valid the cycle after a read |
| per_rx_ready | input | 1 | Peripheral holds a received byte |
| per_rx_data | input | DW | Received byte |
| per_rx_take | output | 1 | Received byte consumed |
| per_tx_ready | input | 1 | Peripheral can accept a byte |
| per_tx_data | output | DW | Byte for the peripheral |
| per_tx_load | output | 1 | `per_tx_data` is valid; peripheral loads it |
| end_rx | output | 1 | rx active length is 0 |
| rx_full | output | 1 | Both rx lengths are 0 |
| end_tx | output | 1 | tx active length is 0 |
| tx_empty | output | 1 | Both tx lengths are 0 |

## Verification
The bench runs a receive stream that crosses from the active buffer into the queued one. It checks that every byte lands at the right address and that exactly one cycle shows end-of-buffer without full. A design that skipped the hand-over, or that did not clear the queued length, would write past the first buffer or run the second buffer twice.

It writes the active length to zero while the direction is disabled, to show that the hand-over does not wait for enable. It also holds the peripheral ready while the direction is disabled, which catches a design that moves data anyway.

Two more cases are covered. A command with both enable and disable bits set must end disabled. When both directions are ready in the same cycle, the memory port must go to the receive side.

// File: rtl/pdc_chan.sv
module pdc_chan #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [5:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          per_rx_ready,
  input  logic [DW-1:0] per_rx_data,
  output logic          per_rx_take,
  input  logic          per_tx_ready,
  output logic [DW-1:0] per_tx_data,
  output logic          per_tx_load,
  output logic          end_rx,
  output logic          rx_full,
  output logic          end_tx,
  output logic          tx_empty
);
  localparam int RW = 32;
  localparam logic [3:0] W_CMD  = 4'd8;
  localparam logic [3:0] W_STAT = 4'd9;

  logic [AW-1:0] ptr [2];
  logic [AW-1:0] nptr [2];
  logic [CW-1:0] cnt [2];
  logic [CW-1:0] ncnt [2];
  logic [1:0]    en;
  logic          tx_busy;
  logic [3:0]    widx;
  logic [1:0]    reload, done;
  logic          rx_go, tx_go;
  logic          unused_bits;

  assign widx        = reg_addr[5:2];
  assign unused_bits = ^{reg_wdata, reg_addr[1:0]};

  assign rx_go = en[0] && (cnt[0] != '0) && per_rx_ready && !tx_busy;
  assign tx_go = en[1] && (cnt[1] != '0) && per_tx_ready && !tx_busy && !rx_go;
  assign done  = {tx_busy, rx_go};

  assign reload[0] = (cnt[0] == '0) && (ncnt[0] != '0);
  assign reload[1] = (cnt[1] == '0) && (ncnt[1] != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < 2; d++) begin
        ptr[d]  <= '0;
        nptr[d] <= '0;
        cnt[d]  <= '0;
        ncnt[d] <= '0;
      end
      en      <= '0;
      tx_busy <= 1'b0;
    end else begin
      tx_busy <= tx_go;
      for (int d = 0; d < 2; d++) begin
        if (reg_we && widx == 4'(2*d))
          ptr[d] <= reg_wdata[AW-1:0];
        else if (reload[d])
          ptr[d] <= nptr[d];
        else if (done[d] && cnt[d] != '0)
          ptr[d] <= ptr[d] + 1'b1;

        if (reg_we && widx == 4'(2*d+1))
          cnt[d] <= reg_wdata[CW-1:0];
        else if (reload[d])
          cnt[d] <= ncnt[d];
        else if (done[d] && cnt[d] != '0)
          cnt[d] <= cnt[d] - 1'b1;

        if (reg_we && widx == 4'(4+2*d))
          nptr[d] <= reg_wdata[AW-1:0];

        if (reg_we && widx == 4'(5+2*d))
          ncnt[d] <= reg_wdata[CW-1:0];
        else if (reload[d])
          ncnt[d] <= '0;

        if (reg_we && widx == W_CMD)
          en[d] <= reg_wdata[8*d+1] ? 1'b0 : (reg_wdata[8*d] | en[d]);
      end
    end
  end

  assign mem_req     = rx_go | tx_go;
  assign mem_we      = rx_go;
  assign mem_addr    = rx_go ? ptr[0] : ptr[1];
  assign mem_wdata   = per_rx_data;
  assign per_rx_take = rx_go;
  assign per_tx_load = tx_busy;
  assign per_tx_data = mem_rdata;

  assign end_rx   = (cnt[0] == '0);
  assign rx_full  = end_rx && (ncnt[0] == '0);
  assign end_tx   = (cnt[1] == '0);
  assign tx_empty = end_tx && (ncnt[1] == '0);

  always_comb begin
    case (widx)
      4'd0:    reg_rdata = RW'(ptr[0]);
      4'd1:    reg_rdata = RW'(cnt[0]);
      4'd2:    reg_rdata = RW'(ptr[1]);
      4'd3:    reg_rdata = RW'(cnt[1]);
      4'd4:    reg_rdata = RW'(nptr[0]);
      4'd5:    reg_rdata = RW'(ncnt[0]);
      4'd6:    reg_rdata = RW'(nptr[1]);
      4'd7:    reg_rdata = RW'(ncnt[1]);
      W_STAT:  reg_rdata = {23'b0, en[1], 7'b0, en[0]};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pdc_chan_chk.sv
module pdc_chan_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic          ctl_we,
  input logic [1:0]    ctl_bits,
  input logic          mem_req,
  input logic          mem_we,
  input logic          per_rx_ready,
  input logic          per_rx_take,
  input logic          per_tx_load,
  input logic          rx_en,
  input logic [CW-1:0] rx_cnt,
  input logic          end_rx,
  input logic          rx_full
);
  // R5
  rx_take_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_rx_take |-> mem_req && mem_we);

  // R7
  rx_take_needs_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_rx_take |-> rx_en && rx_cnt != '0);

  // R5
  rx_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_rx_take && !reg_we |=> rx_cnt == $past(rx_cnt) - 1'b1);

  // R6
  tx_load_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_tx_load |-> $past(mem_req && !mem_we));

  // R10
  full_implies_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> end_rx);

  // R4
  both_bits_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && ctl_bits == 2'b11 |=> !rx_en);

  // R11
  rx_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |-> !(rx_en && rx_cnt != '0 && per_rx_ready));
endmodule

bind pdc_chan pdc_chan_chk #(.CW(CW)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .reg_we(reg_we),
  .ctl_we(reg_we && reg_addr == 6'h20),
  .ctl_bits(reg_wdata[1:0]),
  .mem_req(mem_req),
  .mem_we(mem_we),
  .per_rx_ready(per_rx_ready),
  .per_rx_take(per_rx_take),
  .per_tx_load(per_tx_load),
  .rx_en(en[0]),
  .rx_cnt(cnt[0]),
  .end_rx(end_rx),
  .rx_full(rx_full)
);

// File: tb/pdc_chan_bench.sv
module pdc_chan_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;
  // {write addr, write data, read addr, expected}
  localparam logic [31:0] VEC [NV][4] = '{
    '{32'h00, 32'h1234,     32'h00, 32'h1234},
    '{32'h04, 32'h0005,     32'h04, 32'h0005},
    '{32'h08, 32'hBEEF,     32'h08, 32'hBEEF},
    '{32'h0C, 32'h0007,     32'h0C, 32'h0007},
    '{32'h10, 32'h4000,     32'h10, 32'h4000},
    '{32'h14, 32'h0003,     32'h14, 32'h0003},
    '{32'h18, 32'h5555,     32'h18, 32'h5555},
    '{32'h1C, 32'h0002,     32'h1C, 32'h0002},
    '{32'h20, 32'h0001,     32'h24, 32'h0001},
    '{32'h20, 32'h0100,     32'h24, 32'h0101},
    '{32'h20, 32'h0002,     32'h24, 32'h0100},
    '{32'h20, 32'h0200,     32'h24, 32'h0000},
    '{32'h00, 32'hFFFFFFFF, 32'h00, 32'h0000FFFF},
    '{32'h20, 32'h0101,     32'h24, 32'h0101},
    '{32'h20, 32'h0303,     32'h24, 32'h0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        per_rx_ready = 1'b0;
  logic [7:0]  per_rx_data;
  logic        per_rx_take;
  logic        per_tx_ready = 1'b0;
  logic [7:0]  per_tx_data;
  logic        per_tx_load;
  logic        end_rx, rx_full, end_tx, tx_empty;

  int nchk = 0;
  int nerr = 0;
  int takes = 0;
  int nload = 0;
  int gaps = 0;
  logic [7:0] mem [256];
  logic [7:0] cap [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  pdc_chan u_pdc_chan (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .per_rx_ready(per_rx_ready), .per_rx_data(per_rx_data), .per_rx_take(per_rx_take),
    .per_tx_ready(per_tx_ready), .per_tx_data(per_tx_data), .per_tx_load(per_tx_load),
    .end_rx(end_rx), .rx_full(rx_full), .end_tx(end_tx), .tx_empty(tx_empty)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
      mem_rdata   <= '0;
      per_rx_data <= 8'hC0;
    end else begin
      if (mem_req && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[7:0]];
      if (per_rx_take) begin
        per_rx_data <= per_rx_data + 8'd1;
        takes <= takes + 1;
      end
      if (per_tx_load) begin
        cap[nload[3:0]] <= per_tx_data;
        nload <= nload + 1;
      end
    end
  end

  always @(negedge clk) if (rst_n && end_rx && !rx_full) gaps <= gaps + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int base, gbase;
    logic [7:0] b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    for (int w = 0; w < 10; w++) begin
      rd(6'(4*w), v);
      chk("R2 reset register", v, 32'h0);
    end
    chk("R2 reset flags", {28'h0, end_rx, rx_full, end_tx, tx_empty}, 32'hF);

    // R1 R3 R4 register vectors
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][0][5:0], VEC[i][1]);
      rd(VEC[i][2][5:0], v);
      chk(i < 8 ? "R1 readback" : (i == 12 ? "R1 truncate" : (i == 14 ? "R4 both bits" : "R3 command")),
          v, VEC[i][3]);
    end

    // R8 reload while disabled
    wr(6'h04, 32'h0);
    @(negedge clk);
    rd(6'h00, v); chk("R8 reload address", v, 32'h4000);
    rd(6'h04, v); chk("R8 reload length", v, 32'h3);
    rd(6'h14, v); chk("R8 queued length cleared", v, 32'h0);

    // R7 disabled direction ignores ready
    base = takes;
    per_rx_ready = 1'b1;
    repeat (8) @(negedge clk);
    per_rx_ready = 1'b0;
    chk("R7 no take while disabled", 32'(takes - base), 32'h0);
    rd(6'h04, v); chk("R7 length unchanged", v, 32'h3);

    // R5 R8 R9 R10 rx stream across both buffers
    wr(6'h00, 32'h10); wr(6'h04, 32'h3);
    wr(6'h10, 32'h40); wr(6'h14, 32'h2);
    base = takes; gbase = gaps; b0 = per_rx_data;
    chk("R10 rx not full when loaded", {31'h0, rx_full}, 32'h0);
    per_rx_ready = 1'b1;
    wr(6'h20, 32'h1);
    for (int k = 0; k < 300 && (takes - base) < 5; k++) @(negedge clk);
    repeat (5) @(negedge clk);
    per_rx_ready = 1'b0;
    chk("R7 rx stops at zero", 32'(takes - base), 32'h5);
    chk("R5 byte 0", {24'h0, mem[8'h10]}, {24'h0, b0});
    chk("R5 byte 2", {24'h0, mem[8'h12]}, {24'h0, b0 + 8'd2});
    chk("R8 byte in queued buffer", {24'h0, mem[8'h40]}, {24'h0, b0 + 8'd3});
    chk("R8 last byte", {24'h0, mem[8'h41]}, {24'h0, b0 + 8'd4});
    chk("R5 no write past first buffer", {24'h0, mem[8'h13]}, 32'h13 ^ 32'h5A);
    rd(6'h00, v); chk("R5 final rx address", v, 32'h42);
    rd(6'h04, v); chk("R5 final rx length", v, 32'h0);
    chk("R9 end without full seen once", 32'(gaps - gbase), 32'h1);
    chk("R10 rx full", {30'h0, end_rx, rx_full}, 32'h3);

    // R6 R9 R10 tx stream
    wr(6'h20, 32'h2);
    wr(6'h08, 32'h80); wr(6'h0C, 32'h2);
    wr(6'h18, 32'hA0); wr(6'h1C, 32'h1);
    base = nload;
    chk("R9 tx end low while active", {31'h0, end_tx}, 32'h0);
    per_tx_ready = 1'b1;
    wr(6'h20, 32'h100);
    for (int k = 0; k < 300 && (nload - base) < 3; k++) @(negedge clk);
    repeat (4) @(negedge clk);
    per_tx_ready = 1'b0;
    chk("R6 tx count", 32'(nload - base), 32'h3);
    chk("R6 tx byte 0", {24'h0, cap[4'(base)]},   32'h80 ^ 32'h5A);
    chk("R6 tx byte 1", {24'h0, cap[4'(base+1)]}, 32'h81 ^ 32'h5A);
    chk("R8 tx byte from queued", {24'h0, cap[4'(base+2)]}, 32'hA0 ^ 32'h5A);
    rd(6'h08, v); chk("R6 final tx address", v, 32'hA1);
    chk("R10 tx empty", {30'h0, end_tx, tx_empty}, 32'h3);

    // R11 rx wins the port
    wr(6'h20, 32'h200);
    wr(6'h04, 32'h1); wr(6'h0C, 32'h1);
    base = nload;
    per_rx_ready = 1'b1; per_tx_ready = 1'b1;
    wr(6'h20, 32'h101);
    for (int k = 0; k < 20 && !mem_req; k++) @(negedge clk);
    chk("R11 first access is rx write", {30'h0, mem_req, mem_we}, 32'h3);
    for (int k = 0; k < 50 && (nload - base) < 1; k++) @(negedge clk);
    repeat (2) @(negedge clk);
    per_rx_ready = 1'b0; per_tx_ready = 1'b0;
    chk("R11 tx served after rx", {24'h0, cap[4'(base)]}, 32'hA1 ^ 32'h5A);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule